// File: doc/BRIEF.md
# Triangular-Window Averaging Filter

This block smooths a stream of signed sensor words with a triangular (Bartlett) FIR window. The window is built from two identical moving-average stages in cascade. Each stage averages its last N = 2^M inputs and scales the result by N with an arithmetic right shift, so the filter uses no multipliers. The cascade of two boxcars gives the squared boxcar response, which is the triangular window.

The window exponent M comes from a small control input and may change while data is flowing. A change of the effective M clears both stages, so no samples are mixed across settings. M = 0 makes the block a plain two-cycle pipeline that passes the data through unchanged. Each accepted input word produces exactly one output word, so the output rate equals the input rate.

Top module: `tri_avg_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: Each accepted sample (`in_valid` high on a cycle with no flush) produces exactly one output with `out_valid` high two clock edges later. No output appears otherwise.
- R3: With effective M = 0, each output equals the input sample accepted two edges earlier.
- R4: Each stage's output is floor(S / N), where S is the sum of the stage's last N inputs since the last flush, older positions count as 0, and N = 2^M. The second stage takes the first stage's outputs as its inputs. The filter output is the second stage's output.
- R5: With a constant input held for at least 2N−1 accepted samples after a flush, the output equals that constant.
- R6: When the effective M differs from the one in use, that cycle is a flush. Both stages clear their history and sums, the sample offered in that cycle is dropped without output, and the new M applies from the next cycle.
- R7: `m_sel` values above 6 are treated as 6. Moving `m_sel` between two values with the same effective M causes no flush.
- R8: Full-scale inputs at M = 6 (all +32767 or all −32768 for 16-bit data) produce exactly that value after settling, with no wrap-around.
- R9: Cycles with `in_valid` low leave all filter state unchanged, so gaps in the stream do not change any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_sel | input | 3 | Window exponent request; N = 2^min(m_sel,6) |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 16 | Signed filtered output |

## Verification
The bench drives step and constant inputs at every M from 0 to 6, and pseudo-random signed data with idle gaps. Each output is compared with a floor-division model of the two cascaded windows. A design that truncated toward zero instead of flooring would be off by one on negative data. A design that took the leaving sample from the wrong delay position would drift away from the model once the window fills. Each M change is made with a sample offered in the same cycle: a design that kept stale history would give wrong early outputs, and one that passed the dropped sample on would raise an output with nothing expected. Full-scale runs at M = 6 and an out-of-range `m_sel` expose a narrow accumulator through wrap-around and a missing clamp through a wrong window length.

// File: rtl/tri_avg_pkg.sv
package tri_avg_pkg;
  // Effective exponent: requests above the limit saturate.
  function automatic int clamp_m(input int req, input int lim);
    return (req > lim) ? lim : req;
  endfunction

  // Number of taps for a given exponent.
  function automatic int win_len(input int m);
    return 1 << m;
  endfunction
endpackage

// File: rtl/m_tracker.sv
module m_tracker #(
  parameter int MMAX = 6,
  parameter int MW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_sel,
  output logic [MW-1:0] m_q,
  output logic          flush
);
  logic [MW-1:0] m_lim;

  always_comb begin
    m_lim = MW'(tri_avg_pkg::clamp_m(int'(m_sel), MMAX));
    flush = (m_lim != m_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= '0;
    else        m_q <= m_lim;
  end
endmodule

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
  parameter int DW   = 16,
  parameter int MMAX = 6,
  parameter int MW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [MW-1:0]        m,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int DEPTH = 1 << MMAX;
  localparam int AW    = DW + MMAX + 1;

  logic signed [DW-1:0] dline [DEPTH];
  logic signed [AW-1:0] acc, acc_nxt;
  logic signed [DW-1:0] oldest;

  function automatic logic signed [DW-1:0] scale_down(input logic signed [AW-1:0] s,
                                                      input logic [MW-1:0] sh);
    logic signed [AW-1:0] q;
    q = s >>> sh;
    return q[DW-1:0];
  endfunction

  always_comb begin
    oldest = '0;
    for (int i = 0; i < DEPTH; i++)
      if (i == tri_avg_pkg::win_len(int'(m)) - 1) oldest = dline[i];
    acc_nxt = acc + {{(AW-DW){in_data[DW-1]}}, in_data}
                  - {{(AW-DW){oldest[DW-1]}}, oldest};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dline[i] <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) dline[i] <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dline[0] <= in_data;
        for (int i = 1; i < DEPTH; i++) dline[i] <= dline[i-1];
        acc      <= acc_nxt;
        out_data <= scale_down(acc_nxt, m);
      end
    end
  end
endmodule

// File: rtl/tri_avg_filter.sv
module tri_avg_filter #(
  parameter  int DW   = 16,
  parameter  int MMAX = 6,
  localparam int MW   = $clog2(MMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MW-1:0]        m_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  logic [MW-1:0]        m_q;
  logic                 flush;
  logic                 take;
  logic                 s1_valid;
  logic signed [DW-1:0] s1_data;

  m_tracker #(.MMAX(MMAX), .MW(MW)) u_mtrk (
    .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_q(m_q), .flush(flush)
  );

  assign take = in_valid & ~flush;

  boxcar_stage #(.DW(DW), .MMAX(MMAX), .MW(MW)) u_st1 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .m(m_q),
    .in_valid(take), .in_data(in_data),
    .out_valid(s1_valid), .out_data(s1_data)
  );

  boxcar_stage #(.DW(DW), .MMAX(MMAX), .MW(MW)) u_st2 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .m(m_q),
    .in_valid(s1_valid), .in_data(s1_data),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/tri_avg_chk.sv
module tri_avg_chk #(
  parameter int DW   = 16,
  parameter int MMAX = 6,
  parameter int MW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 take,
  input logic                 flush,
  input logic                 s1_valid,
  input logic [MW-1:0]        m_q,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);
  AST_TAKE_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> s1_valid); // R2
  AST_IDLE_NO_S1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !s1_valid); // R2
  AST_S1_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !flush) |=> out_valid); // R2
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!s1_valid && !out_valid)); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_q == '0) |=> ##1 (!out_valid || out_data == $past(in_data, 2))); // R3
  AST_M_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    m_q <= MW'(MMAX)); // R7
endmodule

bind tri_avg_filter tri_avg_chk #(.DW(DW), .MMAX(MMAX), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .s1_valid(s1_valid),
  .m_q(m_q), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tri_avg_filter_tb.sv
module tri_avg_filter_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         m_sel = '0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R4";
  int cm = 0;
  int hx[64];
  int hs[64];
  int last_out = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  tri_avg_filter u_dut (
    .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  function automatic int fdiv(input int s, input int n);
    int q;
    q = s / n;
    if ((s % n) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 64; i++) begin hx[i] = 0; hs[i] = 0; end
  endtask

  task automatic send(input int x);
    int n, s, s1, y;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    n = 1 << cm;
    for (int i = 63; i > 0; i--) hx[i] = hx[i-1];
    hx[0] = x;
    s = 0;
    for (int i = 0; i < n; i++) s += hx[i];
    s1 = fdiv(s, n);
    for (int i = 63; i > 0; i--) hs[i] = hs[i-1];
    hs[0] = s1;
    s = 0;
    for (int i = 0; i < n; i++) s += hs[i];
    y = fdiv(s, n);
    exp_q.push_back(y);
    tag_q.push_back(cur_tag);
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R6: a change of effective M is offered together with a sample that must vanish.
  task automatic set_m(input int m, input int x);
    int eff;
    eff = (m > 6) ? 6 : m;
    @(negedge clk);
    m_sel = 3'(m);
    if (eff != cm) begin
      in_valid = 1'b1;
      in_data  = 16'(x);
      clear_hist();
      cm = eff;
    end else begin
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(4);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
  endtask

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", int'(out_data), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(out_data) == e, t, int'(out_data), e);
        end
        last_out = int'(out_data);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_hist();
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && out_data == 16'sd0, "R1", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(out_valid == 1'b0 && out_data == 16'sd0, "R1", int'(out_data), 0);

    // R3: pass-through at M = 0
    cur_tag = "R3";
    for (int i = 0; i < 10; i++) send(next_rand());
    drain();

    // R4/R5: step response for every M
    for (int m = 1; m <= 6; m++) begin
      cur_tag = "R4";
      set_m(m, 12345);
      for (int i = 0; i < 3; i++) send(0);
      for (int i = 0; i < (2 << m) + 2; i++) send(900);
      drain();
      check(last_out == 900, "R5", last_out, 900);
    end

    // R5: negative constant, M = 3
    cur_tag = "R5";
    set_m(3, 77);
    for (int i = 0; i < 15; i++) send(-7);
    drain();
    check(last_out == -7, "R5", last_out, -7);

    // R9: random signed data with gaps, M = 2 and M = 5
    cur_tag = "R9";
    set_m(2, -500);
    for (int i = 0; i < 40; i++) begin
      send(next_rand());
      if (i % 3 == 0) idle(2);
    end
    drain();
    cur_tag = "R4";
    set_m(5, 31000);
    for (int i = 0; i < 90; i++) begin
      send(next_rand());
      if (i % 7 == 0) idle(1);
    end
    drain();

    // R7: m_sel = 7 acts as 6; stepping 6 -> 7 keeps history
    cur_tag = "R7";
    set_m(7, 4);
    for (int i = 0; i < 20; i++) send(next_rand());
    set_m(6, 0);
    for (int i = 0; i < 20; i++) send(next_rand());
    set_m(7, 0);
    for (int i = 0; i < 20; i++) send(next_rand());
    drain();

    // R8: full scale at M = 6
    cur_tag = "R8";
    set_m(0, 1);
    set_m(6, -1);
    for (int i = 0; i < 130; i++) send(32767);
    drain();
    check(last_out == 32767, "R8", last_out, 32767);
    for (int i = 0; i < 130; i++) send(-32768);
    drain();
    check(last_out == -32768, "R8", last_out, -32768);

    // R6: back-to-back M changes, each with a dropped sample
    cur_tag = "R6";
    set_m(1, 999);
    set_m(4, -999);
    for (int i = 0; i < 12; i++) send(100 + i);
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule